// File: doc/BRIEF.md
# Three-Phase Gate Command Sequencer

This block sits between a motor or converter controller and the gate drivers of three half-bridge legs. Each leg has two command inputs: a low-side command that is active high, and a high-side command that is active low. The block turns them into two gate-enable outputs per leg, one for the upper switch and one for the lower switch. In normal mode the low-side command wins when the two commands in a leg conflict. A switch that turns on waits for a programmable dead time first. A switch that turns off does so on the next clock edge.

A bypass mode skips both the conflict resolution and the dead time, so the outputs follow the commands and both switches of a leg may be on together. Disable and undervoltage each force all six outputs off at once. When both are released, the block holds every lower switch on for a programmed number of cycles to recharge the upper supplies. Only after that interval do the commands take effect.

Top module: `gate_seq_top`

## Requirements
- R1: `dis_i` high, sampled at a clock edge, drives all six gate outputs to 0 after that edge, whatever the other inputs are.
- R2: `uv_i` high, sampled at a clock edge, drives all six gate outputs to 0 after that edge.
- R3: The high-side command is active low. An upper output can turn on only after its `hi_cmd_n_i` bit was sampled as 0. With `hi_cmd_n_i` bit 1 and `lo_cmd_i` bit 0 in normal mode, both outputs of that leg turn off.
- R4: In normal mode (`bypass_i` = 0), a `lo_cmd_i` bit of 1 turns the upper output of that leg off at the next edge, whatever `hi_cmd_n_i` is, and requests the lower output on. The two outputs of a leg are never on together unless bypass was sampled high at the edge that produced them.
- R5: In normal mode, `lo_cmd_i` bit 0 with `hi_cmd_n_i` bit 0 requests the upper output on and turns the lower output off at the next edge.
- R6: With `bypass_i` = 1, each output takes its commanded value at the next edge with no dead time: lower = `lo_cmd_i` bit, upper = inverse of `hi_cmd_n_i` bit. Both can be on together.
- R7: In normal mode, a requested turn-on appears D edges after the edge that first samples the new request. D is `dt_cycles_i`, and a value of 0 counts as 1. If the request changes before the count ends, the count restarts from the new request. A request that keeps an output in its current on state adds no delay.
- R8: In the cycle after `dis_i` and `uv_i` are both sampled low from the off state, a refresh begins. All three lower outputs are on and all upper outputs are off for exactly R cycles, where R is `refresh_cycles_i` sampled at the start and a value of 0 counts as 1. Commands are ignored during the refresh and take effect at the edge after it ends.
- R9: Asserting `dis_i` or `uv_i` during a refresh aborts it and turns all outputs off. A complete new refresh runs after the next release.
- R10: Each leg has its own dead-time counter. A change in one leg neither delays nor restarts the turn-on of another leg.
- R11: While `rst_i` is high, all outputs are 0. After reset the block begins with the refresh sequence of R8 before it follows any command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| dis_i | input | 1 | Disable; forces all gates off |
| uv_i | input | 1 | Undervoltage flag; forces all gates off |
| bypass_i | input | 1 | 1 = outputs follow commands with no dead time or conflict rule |
| lo_cmd_i | input | NPH (3) | Low-side command per leg, active high |
| hi_cmd_n_i | input | NPH (3) | High-side command per leg, active low |
| dt_cycles_i | input | DT_W (8) | Turn-on delay in clock cycles (0 treated as 1) |
| refresh_cycles_i | input | RF_W (12) | Refresh length in clock cycles (0 treated as 1) |
| gate_hi_o | output | NPH (3) | Upper gate enables, bit p for leg p |
| gate_lo_o | output | NPH (3) | Lower gate enables, bit p for leg p |

## Verification
Disable, undervoltage, turn-off and bypass results are due one edge after the edge that samples their cause. A normal-mode turn-on is due D edges after the edge that samples the request. Refresh lowers are on from the edge after release for R edges. The bench keeps a cycle model that advances at each rising edge from the inputs that edge sampled. It compares all six outputs one nanosecond after that edge, so every check lands in the cycle where the result is due. The dead-time and refresh lengths are changed only while disable is held, so each count runs against a single programmed value.

// File: rtl/gate_seq_pkg.sv
`timescale 1ns/1ps
package gate_seq_pkg;

    typedef enum logic [1:0] {
        SEQ_OFF     = 2'd0,
        SEQ_REFRESH = 2'd1,
        SEQ_RUN     = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic hi;
        logic lo;
    } gate_pair_t;

    localparam gate_pair_t PAIR_LO_ONLY = '{hi: 1'b0, lo: 1'b1};
    localparam gate_pair_t PAIR_NONE    = '{hi: 1'b0, lo: 1'b0};

    // Requested leg state from the two commands and the mode
    function automatic gate_pair_t leg_request(input logic lo_cmd,
                                               input logic hi_cmd_n,
                                               input logic bypass);
        gate_pair_t r;
        r.lo = lo_cmd;
        if (bypass)
            r.hi = ~hi_cmd_n;
        else
            r.hi = ~hi_cmd_n & ~lo_cmd;   // low-side command wins
        return r;
    endfunction

endpackage

// File: rtl/gate_seq_refresh.sv
`timescale 1ns/1ps
module gate_seq_refresh
    import gate_seq_pkg::*;
#(
    parameter int RF_W = 12
) (
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic            hold_off_i,
    input  logic [RF_W-1:0] refresh_cycles_i,
    output seq_state_e      state_o
);

    seq_state_e      state_q;
    logic [RF_W-1:0] left_q;
    logic [RF_W-1:0] rf_eff;

    always_comb rf_eff = (refresh_cycles_i == '0) ? RF_W'(1) : refresh_cycles_i;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= SEQ_OFF;
            left_q  <= '0;
        end else if (hold_off_i) begin
            state_q <= SEQ_OFF;
            left_q  <= '0;
        end else begin
            unique case (state_q)
                SEQ_OFF: begin
                    state_q <= SEQ_REFRESH;
                    left_q  <= rf_eff - RF_W'(1);
                end
                SEQ_REFRESH: begin
                    if (left_q == '0)
                        state_q <= SEQ_RUN;
                    else
                        left_q <= left_q - RF_W'(1);
                end
                default: state_q <= SEQ_RUN;
            endcase
        end
    end

    assign state_o = state_q;

    a_r9_hold_aborts: assert property (@(posedge clk_i) disable iff (rst_i)
        hold_off_i |=> state_q == SEQ_OFF);

    a_r8_release_starts_refresh: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == SEQ_OFF && !hold_off_i) |=> state_q == SEQ_REFRESH);

endmodule

// File: rtl/gate_seq_leg.sv
`timescale 1ns/1ps
module gate_seq_leg
    import gate_seq_pkg::*;
#(
    parameter int DT_W = 8
) (
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic            hold_off_i,
    input  seq_state_e      state_i,
    input  logic            bypass_i,
    input  logic            lo_cmd_i,
    input  logic            hi_cmd_n_i,
    input  logic [DT_W-1:0] dt_cycles_i,
    output gate_pair_t      gate_o
);

    gate_pair_t      req;
    gate_pair_t      pend_q;
    gate_pair_t      out_q;
    logic [DT_W-1:0] cnt_q;
    logic [DT_W-1:0] dt_eff;
    logic            running;

    always_comb begin
        req     = leg_request(lo_cmd_i, hi_cmd_n_i, bypass_i);
        dt_eff  = (dt_cycles_i == '0) ? DT_W'(1) : dt_cycles_i;
        running = !hold_off_i && (state_i == SEQ_RUN);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            out_q  <= PAIR_NONE;
            pend_q <= PAIR_LO_ONLY;
            cnt_q  <= '0;
        end else if (!running) begin
            out_q.hi <= 1'b0;
            out_q.lo <= !hold_off_i && (state_i == SEQ_REFRESH);
            pend_q   <= PAIR_LO_ONLY;
            cnt_q    <= '0;
        end else if (bypass_i) begin
            out_q  <= req;
            pend_q <= req;
            cnt_q  <= '0;
        end else if (req != pend_q) begin
            out_q  <= gate_pair_t'(out_q & req);   // turn-off at once
            pend_q <= req;
            cnt_q  <= dt_eff - DT_W'(1);
        end else if (cnt_q != '0) begin
            out_q <= gate_pair_t'(out_q & req);
            cnt_q <= cnt_q - DT_W'(1);
        end else begin
            out_q <= req;
        end
    end

    assign gate_o = out_q;

    a_r4_low_cmd_kills_upper: assert property (@(posedge clk_i) disable iff (rst_i)
        (running && !bypass_i && lo_cmd_i) |=> !out_q.hi);

    a_r4_exclusive_unless_bypass: assert property (@(posedge clk_i) disable iff (rst_i)
        (out_q.hi && out_q.lo) |-> $past(bypass_i));

    a_r3_upper_needs_low_input: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(out_q.hi) |-> !$past(hi_cmd_n_i));

    a_r8_refresh_lower_on: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_i == SEQ_REFRESH && !hold_off_i) |=> (out_q.lo && !out_q.hi));

endmodule

// File: rtl/gate_seq_top.sv
`timescale 1ns/1ps
module gate_seq_top
    import gate_seq_pkg::*;
#(
    parameter int NPH  = 3,
    parameter int DT_W = 8,
    parameter int RF_W = 12
) (
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic            dis_i,
    input  logic            uv_i,
    input  logic            bypass_i,
    input  logic [NPH-1:0]  lo_cmd_i,
    input  logic [NPH-1:0]  hi_cmd_n_i,
    input  logic [DT_W-1:0] dt_cycles_i,
    input  logic [RF_W-1:0] refresh_cycles_i,
    output logic [NPH-1:0]  gate_hi_o,
    output logic [NPH-1:0]  gate_lo_o
);

    logic       hold_off;
    seq_state_e seq_state;
    gate_pair_t leg_gate [NPH];

    always_comb hold_off = dis_i | uv_i;

    gate_seq_refresh #(.RF_W(RF_W)) u_refresh (
        .clk_i            (clk_i),
        .rst_i            (rst_i),
        .hold_off_i       (hold_off),
        .refresh_cycles_i (refresh_cycles_i),
        .state_o          (seq_state)
    );

    for (genvar p = 0; p < NPH; p++) begin : g_leg
        gate_seq_leg #(.DT_W(DT_W)) u_leg (
            .clk_i       (clk_i),
            .rst_i       (rst_i),
            .hold_off_i  (hold_off),
            .state_i     (seq_state),
            .bypass_i    (bypass_i),
            .lo_cmd_i    (lo_cmd_i[p]),
            .hi_cmd_n_i  (hi_cmd_n_i[p]),
            .dt_cycles_i (dt_cycles_i),
            .gate_o      (leg_gate[p])
        );
        assign gate_hi_o[p] = leg_gate[p].hi;
        assign gate_lo_o[p] = leg_gate[p].lo;
    end

    a_r1_disable_all_off: assert property (@(posedge clk_i) disable iff (rst_i)
        dis_i |=> (gate_hi_o == '0 && gate_lo_o == '0));

    a_r2_undervolt_all_off: assert property (@(posedge clk_i) disable iff (rst_i)
        uv_i |=> (gate_hi_o == '0 && gate_lo_o == '0));

endmodule

// File: tb/gate_seq_top_tb.sv
`timescale 1ns/1ps
module gate_seq_top_tb;

    localparam int NPH = 3;

    logic        clk = 1'b0;
    logic        rst;
    logic        dis, uv, bypass;
    logic [2:0]  lo_cmd, hi_cmd_n;
    logic [7:0]  dt;
    logic [11:0] rf;
    logic [2:0]  gate_hi, gate_lo;

    int checks = 0;
    int failures = 0;

    // model state
    int m_st;          // 0 off, 1 refresh, 2 run
    int m_rleft;
    bit m_hi [NPH];
    bit m_lo [NPH];
    bit l_hi [NPH];
    bit l_lo [NPH];
    int m_age [NPH];

    always #2 clk = ~clk;

    gate_seq_top u_dut (
        .clk_i(clk), .rst_i(rst), .dis_i(dis), .uv_i(uv), .bypass_i(bypass),
        .lo_cmd_i(lo_cmd), .hi_cmd_n_i(hi_cmd_n), .dt_cycles_i(dt),
        .refresh_cycles_i(rf), .gate_hi_o(gate_hi), .gate_lo_o(gate_lo)
    );

    function automatic int dval();
        return (dt == 0) ? 1 : int'(dt);
    endfunction

    function automatic string auto_tag();
        if (rst) return "R11";
        if ((dis || uv) && m_st == 1) return "R9";
        if (dis) return "R1";
        if (uv) return "R2";
        if (m_st != 2) return "R8";
        if (bypass) return "R6";
        for (int p = 0; p < NPH; p++) if (m_age[p] < dval()) return "R7";
        if (lo_cmd != 0) return "R4";
        return "R5";
    endfunction

    task automatic model_edge();
        int d;
        d = dval();
        if (rst || dis || uv || m_st != 2) begin
            for (int p = 0; p < NPH; p++) begin
                m_hi[p] = 0;
                m_lo[p] = !rst && !dis && !uv && (m_st == 1);
                l_hi[p] = 0; l_lo[p] = 1; m_age[p] = 1000;
            end
        end else begin
            for (int p = 0; p < NPH; p++) begin
                bit rl, rh;
                rl = lo_cmd[p];
                rh = bypass ? !hi_cmd_n[p] : (!lo_cmd[p] && !hi_cmd_n[p]);
                if (bypass) begin
                    m_hi[p] = rh; m_lo[p] = rl; l_hi[p] = rh; l_lo[p] = rl; m_age[p] = 1000;
                end else if (rh != l_hi[p] || rl != l_lo[p]) begin
                    m_hi[p] = m_hi[p] & rh; m_lo[p] = m_lo[p] & rl;
                    l_hi[p] = rh; l_lo[p] = rl; m_age[p] = 1;
                end else if (m_age[p] >= d) begin
                    m_hi[p] = rh; m_lo[p] = rl;
                end else begin
                    m_hi[p] = m_hi[p] & rh; m_lo[p] = m_lo[p] & rl;
                    m_age[p]++;
                end
            end
        end
        if (rst || dis || uv) m_st = 0;
        else if (m_st == 0) begin m_st = 1; m_rleft = (rf == 0) ? 1 : int'(rf); end
        else if (m_st == 1) begin m_rleft--; if (m_rleft == 0) m_st = 2; end
    endtask

    task automatic step(input string tag = "");
        string t;
        logic [2:0] eh, el;
        @(posedge clk);
        t = (tag == "") ? auto_tag() : tag;
        model_edge();
        #1;
        for (int p = 0; p < NPH; p++) begin eh[p] = m_hi[p]; el[p] = m_lo[p]; end
        checks++;
        if (gate_hi !== eh || gate_lo !== el) begin
            failures++;
            $display("FAIL %s: hi=%b lo=%b expected hi=%b lo=%b", t, gate_hi, gate_lo, eh, el);
        end
    endtask

    task automatic steps(input int n, input string tag);
        for (int i = 0; i < n; i++) step(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed1234));
        m_st = 0; m_rleft = 0;
        rst = 1; dis = 0; uv = 0; bypass = 0;
        lo_cmd = 3'b000; hi_cmd_n = 3'b000; dt = 8'd3; rf = 12'd4;
        steps(3, "R11");                       // outputs off in reset
        rst = 0;
        steps(6, "R11");                       // refresh runs first after reset
        hi_cmd_n = 3'b111;
        steps(3, "R3");                        // inactive high-side keeps uppers off
        hi_cmd_n = 3'b110;
        steps(4, "R7");                        // upper of leg 0 after 3 cycles
        lo_cmd = 3'b010;
        steps(4, "R10");                       // leg 1 change leaves leg 0 alone
        lo_cmd = 3'b001;
        steps(4, "R4");                        // conflict: lower wins
        lo_cmd = 3'b000; hi_cmd_n = 3'b011;
        steps(4, "R5");
        hi_cmd_n = 3'b111; step("R7");
        hi_cmd_n = 3'b011; step("R7");          // restart before count ends
        hi_cmd_n = 3'b111; step("R7");
        hi_cmd_n = 3'b011; steps(4, "R7");
        bypass = 1; lo_cmd = 3'b101; hi_cmd_n = 3'b010;
        steps(3, "R6");                        // both on in leg 0 and leg 2
        bypass = 0; uv = 1;
        steps(2, "R2");
        uv = 0;
        steps(2, "R8");
        dis = 1;
        steps(2, "R9");                        // abort mid-refresh
        dt = 8'd0; rf = 12'd0;
        steps(1, "R1");
        dis = 0;
        steps(3, "R8");                        // refresh length 0 counts as 1
        lo_cmd = 3'b000; hi_cmd_n = 3'b000;
        steps(3, "R7");                        // dead time 0 counts as 1
        for (int i = 0; i < 6000; i++) begin
            int r;
            r = int'($urandom % 100);
            if (r < 2) begin
                dis = ~dis;
                if (dis) begin dt = 8'($urandom % 6); rf = 12'($urandom % 7); end
            end else if (r < 4) uv = ~uv;
            else if (r < 5) bypass = ~bypass;
            if (!dis && ($urandom % 100) < 30) begin
                lo_cmd = 3'($urandom); hi_cmd_n = 3'($urandom);
            end
            step();
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule